// File: doc/BRIEF.md
# Predicated Execution Stage with Taint Labels

This block is the register-file execution stage of a small core whose instruction set has no data-dependent branches. A condition is evaluated by a compare instruction into a single predicate flag, and later instructions that should run only under that condition are issued as guarded writes. The instruction stream therefore never changes shape with the data, and the program counter follows a sequence fixed by the program text alone. The only non-sequential step is a loop back-edge whose trip count is a constant in the instruction.

Every register and the predicate carry a one-bit taint label (0 = trusted/public, 1 = untrusted/secret). Labels move with the data. A compare gives the predicate the combined label of its operands. A guarded write gives its destination the predicate's label combined with the label of the written value, whether or not the write commits. This makes a secret-dependent choice visible to downstream policy logic as an ordinary explicit label. The program counter itself is never labelled tainted. Opcodes that would need an indirect memory address or a data-dependent branch are refused: they raise an error pulse and do nothing else.

The stage takes one decoded instruction per cycle when `instr_valid` is high. It also takes an external data word with its label. It exposes every register, every label, the predicate, the program counter, the program-counter label and the error pulse as registered outputs.

Top module: `pred_taint_core`

## Requirements
- R1: A synchronous active-high reset clears every register value, every register label, the predicate flag, the predicate label, the program counter, the program-counter label, the error flag and the loop counter to 0.
- R2: Opcode 1 (load immediate) writes `instr_imm` to register `instr_rd` and sets that register's label to 0, whatever the predicate flag and predicate label are.
- R3: Opcode 2 (add) writes `rs1 + rs2` modulo 2^DATA_W to `instr_rd`, with label equal to the OR of the two source labels.
- R4: Opcode 3 sets the predicate flag to (`rs1 == rs2`). Opcode 4 sets it to (`rs1 < rs2`), compared as unsigned. Both set the predicate label to the OR of the two source labels.
- R5: Opcode 5 (guarded move) copies `rs1` into `instr_rd` only when the predicate flag is 1. Opcode 6 (guarded immediate) writes `instr_imm` into `instr_rd` only when the predicate flag is 1. In both cases the destination label becomes the predicate label ORed with the source label (0 for the immediate), even when the data is not written.
- R6: Opcode 7 (input) writes `ext_data` to `instr_rd` with label `ext_label`.
- R7: Opcode 8 (bounded loop) uses `instr_bound` as a constant trip count and `instr_imm[PC_W-1:0]` as the back-edge target. The stage branches back to the target on the first `instr_bound - 1` executions and falls through to `pc + 1` on the next one, resetting its counter. A bound of 0 or 1 always falls through.
- R8: Opcodes 9 to 15 (indirect load, indirect store, data-dependent branch and reserved codes) set `err` to 1 for exactly the following cycle. They change no register, label or predicate, and they advance the program counter by one.
- R9: `pc_tainted` stays 0 under every instruction sequence, including compares on tainted operands followed by guarded writes.
- R10: Opcode 0 and every other legal non-loop opcode advance the program counter by one modulo 2^PC_W. While `instr_valid` is 0, no state changes and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| instr_op | input | 4 | Opcode |
| instr_rd | input | RA_W | Destination register index |
| instr_rs1 | input | RA_W | First source register index |
| instr_rs2 | input | RA_W | Second source register index |
| instr_imm | input | DATA_W | Immediate value; low PC_W bits are the loop target |
| instr_bound | input | BOUND_W | Constant loop trip count |
| ext_data | input | DATA_W | External input value |
| ext_label | input | 1 | Taint label of `ext_data` |
| reg_data_flat | output | NREG*DATA_W | Register i at bits [i*DATA_W +: DATA_W] |
| reg_label_flat | output | NREG | Label of register i at bit i |
| pred_flag | output | 1 | Predicate flag |
| pred_label | output | 1 | Predicate taint label |
| pc | output | PC_W | Program counter |
| pc_tainted | output | 1 | Program-counter taint label |
| err | output | 1 | Refused-opcode pulse |

## Verification
The embedded assertions check several rules on every cycle. A guarded write always leaves the predicate label in its destination label. A guarded write with a false predicate leaves the destination data untouched. A refused opcode leaves the predicate unchanged and raises the error pulse. A taken loop back-edge lands on its target, and an idle cycle holds the program counter. The bench's reference model is needed for the rest: exact arithmetic wrap, unsigned compare ordering, the trip count of bounded loops including bounds 0 and 1, and the rule that an unguarded immediate write clears a label even while the predicate is tainted. Only the model over whole scenarios can show that the program-counter label stays clear after secret-dependent compares.

// File: rtl/pte_pkg.sv
package pte_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LI   = 4'd1,
    OP_ADD  = 4'd2,
    OP_CEQ  = 4'd3,
    OP_CLT  = 4'd4,
    OP_PMOV = 4'd5,
    OP_PLI  = 4'd6,
    OP_IN   = 4'd7,
    OP_LOOP = 4'd8
  } op_e;

  typedef struct packed {
    logic wr_imm;
    logic wr_alu;
    logic wr_ext;
    logic wr_pmov;
    logic wr_pli;
    logic set_pred;
    logic cmp_lt;
    logic is_loop;
    logic step;
    logic illegal;
  } ctrl_t;

endpackage

// File: rtl/pte_decode.sv
module pte_decode
  import pte_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    if (valid) begin
      case (op)
        OP_NOP:  ctrl.step = 1'b1;
        OP_LI:   begin ctrl.wr_imm  = 1'b1; ctrl.step = 1'b1; end
        OP_ADD:  begin ctrl.wr_alu  = 1'b1; ctrl.step = 1'b1; end
        OP_CEQ:  begin ctrl.set_pred = 1'b1; ctrl.step = 1'b1; end
        OP_CLT:  begin ctrl.set_pred = 1'b1; ctrl.cmp_lt = 1'b1; ctrl.step = 1'b1; end
        OP_PMOV: begin ctrl.wr_pmov = 1'b1; ctrl.step = 1'b1; end
        OP_PLI:  begin ctrl.wr_pli  = 1'b1; ctrl.step = 1'b1; end
        OP_IN:   begin ctrl.wr_ext  = 1'b1; ctrl.step = 1'b1; end
        OP_LOOP: ctrl.is_loop = 1'b1;
        default: begin ctrl.illegal = 1'b1; ctrl.step = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/pte_regfile.sv
module pte_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RA_W-1:0]        ra1,
  input  logic [RA_W-1:0]        ra2,
  output logic [DATA_W-1:0]      rd1,
  output logic [DATA_W-1:0]      rd2,
  output logic                   rl1,
  output logic                   rl2,
  input  logic [RA_W-1:0]        waddr,
  input  logic                   data_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   label_we,
  input  logic                   wlabel,
  output logic [NREG*DATA_W-1:0] data_flat,
  output logic [NREG-1:0]        label_flat
);

  logic [DATA_W-1:0] mem_q [NREG];
  logic [NREG-1:0]   lbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (data_we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lbl_q <= '0;
    else if (label_we) lbl_q[waddr] <= wlabel;
  end

  assign rd1 = mem_q[ra1];
  assign rd2 = mem_q[ra2];
  assign rl1 = lbl_q[ra1];
  assign rl2 = lbl_q[ra2];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign data_flat[g*DATA_W +: DATA_W] = mem_q[g];
  end
  assign label_flat = lbl_q;

  // R5: a label-only update must leave the data word of that register alone
  a_r5_label_only_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (label_we && !data_we) |=> mem_q[$past(waddr)] == $past(mem_q[waddr]));

endmodule

// File: rtl/pte_pred.sv
module pte_pred (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic cond,
  input  logic cond_lbl,
  output logic pred_q,
  output logic pred_lbl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q     <= 1'b0;
      pred_lbl_q <= 1'b0;
    end else if (set_en) begin
      pred_q     <= cond;
      pred_lbl_q <= cond_lbl;
    end
  end

  // R4: predicate only moves on a compare
  a_r4_pred_only_on_compare: assert property (@(posedge clk) disable iff (rst)
    !set_en |=> $stable(pred_q) && $stable(pred_lbl_q));

endmodule

// File: rtl/pte_seq.sv
module pte_seq #(
  parameter int PC_W    = 8,
  parameter int BOUND_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               is_loop,
  input  logic               illegal,
  input  logic [BOUND_W-1:0] bound,
  input  logic [PC_W-1:0]    target,
  input  logic               steer_lbl,
  output logic [PC_W-1:0]    pc_q,
  output logic               pc_lbl_q,
  output logic               err_q
);

  logic [BOUND_W-1:0] lc_q;
  logic [BOUND_W:0]   lc_inc;
  logic               take;

  assign lc_inc = {1'b0, lc_q} + 1'b1;
  assign take   = is_loop && (lc_inc < {1'b0, bound});

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      lc_q     <= '0;
      pc_lbl_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= illegal;
      if (is_loop) pc_lbl_q <= pc_lbl_q | steer_lbl;
      if (take) begin
        pc_q <= target;
        lc_q <= lc_inc[BOUND_W-1:0];
      end else if (is_loop) begin
        pc_q <= pc_q + 1'b1;
        lc_q <= '0;
      end else if (step) begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  // R7: a taken back-edge lands on its target
  a_r7_backedge_target: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == $past(target));

  // R10: no instruction, no movement
  a_r10_idle_holds_pc: assert property (@(posedge clk) disable iff (rst)
    (!step && !is_loop) |=> $stable(pc_q) && !err_q);

endmodule

// File: rtl/pred_taint_core.sv
module pred_taint_core
  import pte_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int DATA_W  = 16,
  parameter int PC_W    = 8,
  parameter int BOUND_W = 4,
  localparam int RA_W   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   instr_valid,
  input  logic [3:0]             instr_op,
  input  logic [RA_W-1:0]        instr_rd,
  input  logic [RA_W-1:0]        instr_rs1,
  input  logic [RA_W-1:0]        instr_rs2,
  input  logic [DATA_W-1:0]      instr_imm,
  input  logic [BOUND_W-1:0]     instr_bound,
  input  logic [DATA_W-1:0]      ext_data,
  input  logic                   ext_label,
  output logic [NREG*DATA_W-1:0] reg_data_flat,
  output logic [NREG-1:0]        reg_label_flat,
  output logic                   pred_flag,
  output logic                   pred_label,
  output logic [PC_W-1:0]        pc,
  output logic                   pc_tainted,
  output logic                   err
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] rd1, rd2, wdata;
  logic              rl1, rl2, wlabel;
  logic              data_we, label_we;
  logic              cond, cond_lbl;

  pte_decode u_dec (.valid(instr_valid), .op(instr_op), .ctrl(ctrl));

  always_comb begin
    data_we  = 1'b0;
    label_we = 1'b0;
    wdata    = instr_imm;
    wlabel   = 1'b0;
    if (ctrl.wr_imm) begin
      data_we = 1'b1; label_we = 1'b1;
    end else if (ctrl.wr_alu) begin
      data_we = 1'b1; label_we = 1'b1;
      wdata = rd1 + rd2; wlabel = rl1 | rl2;
    end else if (ctrl.wr_ext) begin
      data_we = 1'b1; label_we = 1'b1;
      wdata = ext_data; wlabel = ext_label;
    end else if (ctrl.wr_pmov) begin
      data_we = pred_flag; label_we = 1'b1;
      wdata = rd1; wlabel = pred_label | rl1;
    end else if (ctrl.wr_pli) begin
      data_we = pred_flag; label_we = 1'b1;
      wlabel = pred_label;
    end
  end

  assign cond     = ctrl.cmp_lt ? (rd1 < rd2) : (rd1 == rd2);
  assign cond_lbl = rl1 | rl2;

  pte_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr_rs1), .ra2(instr_rs2),
    .rd1(rd1), .rd2(rd2), .rl1(rl1), .rl2(rl2),
    .waddr(instr_rd), .data_we(data_we), .wdata(wdata),
    .label_we(label_we), .wlabel(wlabel),
    .data_flat(reg_data_flat), .label_flat(reg_label_flat)
  );

  pte_pred u_pred (
    .clk(clk), .rst(rst), .set_en(ctrl.set_pred),
    .cond(cond), .cond_lbl(cond_lbl),
    .pred_q(pred_flag), .pred_lbl_q(pred_label)
  );

  // The loop bound and target are instruction fields, never register data,
  // so the steering label of every back-edge decision is clear.
  pte_seq #(.PC_W(PC_W), .BOUND_W(BOUND_W)) u_seq (
    .clk(clk), .rst(rst), .step(ctrl.step), .is_loop(ctrl.is_loop),
    .illegal(ctrl.illegal), .bound(instr_bound),
    .target(instr_imm[PC_W-1:0]), .steer_lbl(1'b0),
    .pc_q(pc), .pc_lbl_q(pc_tainted), .err_q(err)
  );

  // R1: reset leaves a clean state behind
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0) && !err && !pred_flag && !pred_label && (reg_label_flat == '0));

  // R5: a guarded write always carries the predicate label into its target
  a_r5_guard_label: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (instr_op == OP_PMOV || instr_op == OP_PLI) && pred_label)
    |=> reg_label_flat[$past(instr_rd)]);

  // R8: a refused opcode leaves the predicate alone and pulses err
  a_r8_refused_is_noop: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_op >= 4'd9) |=> err && $stable(pred_flag) && $stable(pred_label));

endmodule

// File: tb/test_pred_taint_core.sv
`timescale 1ns/1ps
module test_pred_taint_core;

  localparam int NREG = 8, DW = 16, PW = 8, BW = 4;
  localparam logic [3:0] NOP = 0, LI = 1, ADD = 2, CEQ = 3, CLT = 4,
                         PMOV = 5, PLI = 6, IN = 7, LOOP = 8;

  logic clk = 0, rst = 1;
  logic v = 0;
  logic [3:0] op = 0;
  logic [2:0] rd = 0, rs1 = 0, rs2 = 0;
  logic [DW-1:0] imm = 0, ext = 0;
  logic [BW-1:0] bnd = 0;
  logic extl = 0;
  logic [NREG*DW-1:0] rdat;
  logic [NREG-1:0] rlbl;
  logic pf, pl, pct, er;
  logic [PW-1:0] pcv;

  always #2.5 clk = ~clk;

  pred_taint_core i_pred_taint_core (
    .clk(clk), .rst(rst), .instr_valid(v), .instr_op(op), .instr_rd(rd),
    .instr_rs1(rs1), .instr_rs2(rs2), .instr_imm(imm), .instr_bound(bnd),
    .ext_data(ext), .ext_label(extl), .reg_data_flat(rdat),
    .reg_label_flat(rlbl), .pred_flag(pf), .pred_label(pl), .pc(pcv),
    .pc_tainted(pct), .err(er)
  );

  // behavioural reference
  logic [DW-1:0] m_r [NREG];
  logic          m_l [NREG];
  logic m_p, m_pl, m_err;
  logic [PW-1:0] m_pc;
  int m_lc;
  int checks = 0, errors = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < NREG; i++) begin
      check(tag, $sformatf("reg%0d", i), rdat[i*DW +: DW], m_r[i]);
      check(tag, $sformatf("lbl%0d", i), rlbl[i], m_l[i]);
    end
    check(tag, "pred", pf, m_p);
    check(tag, "pred_label", pl, m_pl);
    check(tag, "pc", pcv, m_pc);
    check("R9", "pc_tainted", pct, 0);
    check(tag, "err", er, m_err);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin m_r[i] = 0; m_l[i] = 0; end
    m_p = 0; m_pl = 0; m_err = 0; m_pc = 0; m_lc = 0;
  endtask

  task automatic do_reset();
    rst = 1; v = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    compare_all("R1");
  endtask

  task automatic step(string tag, logic valid, logic [3:0] o, int d, int a, int b,
                      int im, int bound = 0, int x = 0, logic xl = 0);
    logic [DW-1:0] va, vb;
    v = valid; op = o; rd = d[2:0]; rs1 = a[2:0]; rs2 = b[2:0];
    imm = im[DW-1:0]; bnd = bound[BW-1:0]; ext = x[DW-1:0]; extl = xl;
    va = m_r[a]; vb = m_r[b];
    m_err = 0;
    if (valid) begin
      case (o)
        LI:   begin m_r[d] = im[DW-1:0]; m_l[d] = 0; m_pc++; end
        ADD:  begin m_r[d] = va + vb; m_l[d] = m_l[a] | m_l[b]; m_pc++; end
        CEQ:  begin m_pl = m_l[a] | m_l[b]; m_p = (va == vb); m_pc++; end
        CLT:  begin m_pl = m_l[a] | m_l[b]; m_p = (va < vb); m_pc++; end
        PMOV: begin m_l[d] = m_pl | m_l[a]; if (m_p) m_r[d] = va; m_pc++; end
        PLI:  begin m_l[d] = m_pl; if (m_p) m_r[d] = im[DW-1:0]; m_pc++; end
        IN:   begin m_r[d] = x[DW-1:0]; m_l[d] = xl; m_pc++; end
        LOOP: if (m_lc + 1 < bound) begin m_lc++; m_pc = im[PW-1:0]; end
              else begin m_lc = 0; m_pc++; end
        NOP:  m_pc++;
        default: begin m_err = 1; m_pc++; end
      endcase
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R2 / R6 / R3
    step("R2", 1, LI, 1, 0, 0, 5);
    step("R2", 1, LI, 2, 0, 0, 5);
    step("R6", 1, IN, 3, 0, 0, 0, 0, 16'h1234, 1);
    step("R3", 1, ADD, 4, 1, 3, 0);
    step("R2", 1, LI, 0, 0, 0, 16'hFFFF);
    step("R3", 1, ADD, 5, 0, 1, 0);               // wraps to 4
    // R4 untainted true, R5 commit
    step("R4", 1, CEQ, 0, 1, 2, 0);
    step("R5", 1, PLI, 6, 0, 0, 16'h77);
    step("R5", 1, PMOV, 7, 3, 0, 0);              // commits, label from rs1
    // R4 tainted false, R5 suppressed writes still labelled
    step("R4", 1, CEQ, 0, 1, 3, 0);
    step("R5", 1, PMOV, 6, 1, 0, 0);
    step("R5", 1, PLI, 2, 0, 0, 16'h99);
    step("R2", 1, LI, 2, 0, 0, 16'h42);           // label cleared under tainted P0
    // unsigned less-than
    step("R4", 1, CLT, 0, 1, 3, 0);
    step("R5", 1, PMOV, 5, 1, 0, 0);
    step("R4", 1, CLT, 0, 0, 1, 0);               // 0xFFFF < 5 false, untainted
    step("R4", 1, CLT, 0, 1, 1, 0);               // equal not less
    // refused opcodes
    step("R8", 1, 4'd9, 1, 1, 1, 0);
    step("R8", 1, 4'd10, 2, 2, 2, 0);
    step("R8", 1, 4'd15, 3, 3, 3, 0);
    // idle
    step("R10", 0, LI, 1, 0, 0, 16'hDEAD);
    step("R10", 0, 4'd9, 1, 0, 0, 0);
    step("R10", 1, NOP, 0, 0, 0, 0);
    // bounded loop, bound 3, target 2
    for (int k = 0; k < 3; k++) begin
      step("R10", 1, LI, 4, 0, 0, k);
      step("R7", 1, LOOP, 0, 0, 0, 2, 3);
    end
    step("R7", 1, LOOP, 0, 0, 0, 9, 0);
    step("R7", 1, LOOP, 0, 0, 0, 9, 1);
    step("R7", 1, LOOP, 0, 0, 0, 16'h00F0, 15);
    step("R7", 1, LOOP, 0, 0, 0, 16'h00F0, 15);
    // pc wrap
    for (int k = 0; k < 300; k++) step("R10", 1, NOP, 0, 0, 0, 0);
    // secret-dependent chain must keep pc clean
    step("R9", 1, IN, 1, 0, 0, 0, 0, 16'h0005, 1);
    step("R9", 1, CEQ, 0, 1, 1, 0);
    step("R9", 1, PLI, 3, 0, 0, 16'h1111);
    do_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule